// File: doc/BRIEF.md
# Alternate-byte peripheral transfer sequencer

This block executes one CPU instruction: it moves a data register to or from a run of byte addresses spaced two apart. Byte-wide peripherals that sit on a single lane of a 16-bit bus can then be loaded or read with one instruction. The block receives the 16-bit opcode word and its 16-bit displacement word with a one-cycle `start` strobe. It reads a data register and an address register through a combinational register-file read port, and runs two or four single-byte cycles on a request/acknowledge bus. For loads it writes the assembled value back to the data register, and it ends every instruction with a one-cycle `done` pulse.

The block decodes its own opcode pattern and reports a hit on `match`. An enclosing decoder gives this flag precedence over the bit-operation encodings that share the same opcode space. While the `cfg_en` input is low the block never claims an opcode.

Top module: `altbyte_xfer_seq`

## Requirements
- R1: `match` is 1 exactly when `cfg_en` is 1 and `(opcode & 16'hF1F8)` is one of 16'h0108, 16'h0148, 16'h0188, 16'h01C8.
- R2: `rf_dreg_idx` equals opcode[11:9] and `rf_areg_idx` equals opcode[2:0].
- R3: opcode[6] selects the size: 0 gives exactly 2 byte cycles and 1 gives exactly 4 byte cycles.
- R4: opcode[7] selects the direction: 1 is register to memory (`bus_we`=1) and 0 is memory to register (`bus_we`=0).
- R5: The first byte address is the address register plus the sign-extended displacement, taken modulo 2^32.
- R6: Each later byte address is the previous one plus 2, and the address does not advance after the final acknowledge.
- R7: A store sends the most significant byte first: bits 31:24, 23:16, 15:8 and 7:0 for a long, and bits 15:8 then 7:0 for a word.
- R8: A load places the first fetched byte in the most significant position of the transferred width. A long load writes all 32 bits of the data register.
- R9: A word load writes bits 15:0 and keeps bits 31:16 of the data register. Only the data register selected by opcode[11:9] is written, and the address register is never written.
- R10: While `bus_req` is 1 and `bus_ack` is 0, the next cycle keeps `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` unchanged.
- R11: `done` lasts one cycle. For a store it follows the cycle of the last acknowledge. For a load the writeback cycle (`rf_wr_en`=1) follows the last acknowledge, and `done` follows the writeback.
- R12: A `start` that comes without a `match` starts no bus cycle and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables recognition of the instruction |
| start | input | 1 | Issue strobe, one cycle, with opcode and displacement |
| opcode | input | 16 | Instruction opcode word |
| ext_word | input | 16 | Displacement extension word |
| match | output | 1 | Opcode fits the pattern and the instruction is enabled |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_dreg_idx | output | 3 | Data register read index |
| rf_areg_idx | output | 3 | Address register read index |
| rf_dreg_val | input | 32 | Data register read value |
| rf_areg_val | input | 32 | Address register read value |
| rf_wr_en | output | 1 | Data register write strobe |
| rf_wr_idx | output | 3 | Data register write index |
| rf_wr_data | output | 32 | Data register write value |
| bus_req | output | 1 | Byte cycle request |
| bus_we | output | 1 | 1 for a write cycle |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid with acknowledge |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
The acknowledge of one byte and the step to the next address and data byte happen on the same clock edge. With a zero-wait acknowledge the next request follows with no gap. Runs therefore mix zero-wait acknowledges with random wait states. Each new request is judged against the address and byte the bench expects for that position, and each stalled request must repeat its previous values unchanged. A second overlap occurs when the final acknowledge of a load captures the last byte in the same edge that ends the bus phase. The bench checks the written register value and the exact count of cycles from the last acknowledge to the writeback and to `done`.

// File: rtl/altbyte_pkg.sv
package altbyte_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RIDX_W   = 3;
  localparam int unsigned ADDR_INC = 2;
endpackage

// File: rtl/altbyte_match.sv
module altbyte_match
  import altbyte_pkg::*;
(
  input  logic              cfg_en,
  input  logic [15:0]       opcode,
  output logic              hit,
  output logic              is_long,
  output logic              is_store,
  output logic [RIDX_W-1:0] didx,
  output logic [RIDX_W-1:0] aidx
);
  logic [15:0] masked;

  always_comb begin
    masked   = opcode & 16'hF1F8;
    hit      = cfg_en && ((masked == 16'h0108) || (masked == 16'h0148) ||
                          (masked == 16'h0188) || (masked == 16'h01C8));
    is_long  = opcode[6];
    is_store = opcode[7];
    didx     = opcode[11:9];
    aidx     = opcode[2:0];
  end

  // R1
  always_comb begin
    hit_gate_chk: assert (cfg_en || !hit);
  end
endmodule

// File: rtl/altbyte_addr.sv
module altbyte_addr
  import altbyte_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          adv,
  input  logic          is_long,
  input  logic [AW-1:0] base,
  input  logic [15:0]   disp,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    en     = 1'b0;
    if (ld) begin
      en     = 1'b1;
      addr_d = base + {{(AW-16){disp[15]}}, disp};
      cnt_d  = is_long ? CW'(3) : CW'(1);
    end else if (adv && (cnt_q != '0)) begin
      en     = 1'b1;
      addr_d = addr_q + AW'(ADDR_INC);
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr = addr_q;
  assign last = (cnt_q == '0);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && !last) |=> (addr == $past(addr) + AW'(ADDR_INC)));
  // R6
  addr_hold_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && last) |=> $stable(addr));
endmodule

// File: rtl/altbyte_data.sv
module altbyte_data
  import altbyte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              shift,
  input  logic              is_long,
  input  logic [WORD_W-1:0] dval,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] wbyte,
  output logic [WORD_W-1:0] wb_data
);
  localparam int unsigned HALF = WORD_W / 2;

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [HALF-1:0]   keep_q, keep_d;
  logic              long_q, long_d;
  logic              en;

  always_comb begin
    sreg_d = sreg_q;
    keep_d = keep_q;
    long_d = long_q;
    en     = 1'b0;
    if (ld) begin
      en     = 1'b1;
      sreg_d = is_long ? dval : {dval[HALF-1:0], {HALF{1'b0}}};
      keep_d = dval[WORD_W-1:HALF];
      long_d = is_long;
    end else if (shift) begin
      en     = 1'b1;
      sreg_d = {sreg_q[WORD_W-BYTE_W-1:0], rdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      keep_q <= '0;
      long_q <= 1'b0;
    end else if (en) begin
      sreg_q <= sreg_d;
      keep_q <= keep_d;
      long_q <= long_d;
    end
  end

  assign wbyte   = sreg_q[WORD_W-1 -: BYTE_W];
  assign wb_data = long_q ? sreg_q : {keep_q, sreg_q[HALF-1:0]};

  // R7
  word_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !is_long) |=> (wbyte == $past(dval[15:8])));
  // R9
  word_keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !is_long) |=> (wb_data[31:16] == $past(dval[31:16])));
endmodule

// File: rtl/altbyte_xfer_seq.sv
module altbyte_xfer_seq
  import altbyte_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic        start,
  input  logic [15:0] opcode,
  input  logic [15:0] ext_word,
  output logic        match,
  output logic        busy,
  output logic        done,
  output logic [2:0]  rf_dreg_idx,
  output logic [2:0]  rf_areg_idx,
  input  logic [31:0] rf_dreg_val,
  input  logic [31:0] rf_areg_val,
  output logic        rf_wr_en,
  output logic [2:0]  rf_wr_idx,
  output logic [31:0] rf_wr_data,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  input  logic        bus_ack
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic              dec_long, dec_store;
  logic [RIDX_W-1:0] dec_didx, dec_aidx;

  altbyte_match u_match (
    .cfg_en   (cfg_en),
    .opcode   (opcode),
    .hit      (match),
    .is_long  (dec_long),
    .is_store (dec_store),
    .didx     (dec_didx),
    .aidx     (dec_aidx)
  );

  assign rf_dreg_idx = dec_didx;
  assign rf_areg_idx = dec_aidx;

  seq_state_t        state_q, state_d;
  logic              store_q, store_d;
  logic [RIDX_W-1:0] widx_q, widx_d;
  logic              ld, adv, last;

  always_comb begin
    state_d = state_q;
    store_d = store_q;
    widx_d  = widx_q;
    ld      = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start && match) begin
        ld      = 1'b1;
        store_d = dec_store;
        widx_d  = dec_didx;
        state_d = ST_XFER;
      end
      ST_XFER: if (bus_ack) begin
        adv = 1'b1;
        if (last) state_d = store_q ? ST_DONE : ST_WB;
      end
      ST_WB:   state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ld) begin
        store_q <= store_d;
        widx_q  <= widx_d;
      end
    end
  end

  logic [AW-1:0] addr_w;

  altbyte_addr #(.AW(AW), .CW(2)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ld      (ld),
    .adv     (adv),
    .is_long (dec_long),
    .base    (rf_areg_val[AW-1:0]),
    .disp    (ext_word),
    .addr    (addr_w),
    .last    (last)
  );

  altbyte_data u_data (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ld      (ld),
    .shift   (adv),
    .is_long (dec_long),
    .dval    (rf_dreg_val),
    .rdata   (bus_rdata),
    .wbyte   (bus_wdata),
    .wb_data (rf_wr_data)
  );

  assign bus_addr  = 32'(addr_w);
  assign bus_req   = (state_q == ST_XFER);
  assign bus_we    = bus_req && store_q;
  assign rf_wr_en  = (state_q == ST_WB);
  assign rf_wr_idx = widx_q;
  assign done      = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE);

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                               $stable(bus_we) && $stable(bus_wdata)));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
  // R11
  wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rf_wr_en |=> done);
  // R12
  no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && start && !match) |=> (!busy && !bus_req));
  // R4
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_we |-> !rf_wr_en);
endmodule

// File: tb/tb_altbyte_xfer_seq.sv
`timescale 1ns/1ps
module tb_altbyte_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b1;
  logic        start = 1'b0;
  logic [15:0] opcode = 16'h0;
  logic [15:0] ext_word = 16'h0;
  logic        match, busy, done;
  logic [2:0]  rf_dreg_idx, rf_areg_idx, rf_wr_idx;
  logic [31:0] rf_dreg_val, rf_areg_val, rf_wr_data;
  logic        rf_wr_en, bus_req, bus_we, bus_ack = 1'b0;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  logic [31:0] dregs [8];
  logic [31:0] aregs [8];
  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  altbyte_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .start(start),
    .opcode(opcode), .ext_word(ext_word), .match(match), .busy(busy),
    .done(done), .rf_dreg_idx(rf_dreg_idx), .rf_areg_idx(rf_areg_idx),
    .rf_dreg_val(rf_dreg_val), .rf_areg_val(rf_areg_val),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  function automatic logic [7:0] memf(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic bit exp_match(input bit en, input logic [15:0] op);
    logic [15:0] m;
    m = op & 16'hF1F8;
    return en && (m == 16'h0108 || m == 16'h0148 || m == 16'h0188 || m == 16'h01C8);
  endfunction

  assign rf_dreg_val = dregs[rf_dreg_idx];
  assign rf_areg_val = aregs[rf_areg_idx];
  assign bus_rdata   = memf(bus_addr);

  always @(posedge clk) if (rf_wr_en) dregs[rf_wr_idx] <= rf_wr_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_instr(input logic [15:0] op, input logic [15:0] disp,
                           input int wmax);
    bit          lng, st;
    int          n, k, waitc, gap, guard;
    bit          fresh, after_last, saw_wb;
    logic [31:0] base, dval, accv, expv, pa;
    logic [31:0] asave [8];
    logic [7:0]  pd;
    bit          pw;
    lng  = op[6];
    st   = op[7];
    n    = lng ? 4 : 2;
    dval = dregs[op[11:9]];
    base = aregs[op[2:0]] + {{16{disp[15]}}, disp};
    for (int i = 0; i < 8; i++) asave[i] = aregs[i];
    accv = 32'h0;
    @(negedge clk);
    cfg_en = 1'b1; opcode = op; ext_word = disp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; fresh = 1; waitc = 0; gap = 0; after_last = 0; saw_wb = 0;
    pa = 0; pd = 0; pw = 0;
    guard = 0;
    while (!done && guard < 200) begin
      guard++;
      if (after_last) begin
        gap++;
        if (rf_wr_en) begin
          saw_wb = 1;
          // R11: writeback one cycle after last ack
          chk(gap == 1, "R11 wb timing", gap, 1);
        end
      end
      if (bus_req) begin
        if (fresh) begin
          // R5 R6: address of byte k
          chk(bus_addr == base + 32'(2 * k), "R5/R6 address", bus_addr, base + 32'(2 * k));
          // R4: direction
          chk(bus_we == st, "R4 direction", 32'(bus_we), 32'(st));
          if (st) begin
            expv = (dval >> (8 * (n - 1 - k))) & 32'hFF;
            // R7: store byte order
            chk(bus_wdata == expv[7:0], "R7 store byte", 32'(bus_wdata), expv);
          end
          waitc = int'($urandom_range(wmax, 0));
        end else begin
          // R10: stalled request holds
          chk(bus_addr == pa && bus_wdata == pd && bus_we == pw,
              "R10 hold", bus_addr, pa);
        end
        pa = bus_addr; pd = bus_wdata; pw = bus_we;
        if (waitc == 0) begin
          if (!st) accv = {accv[23:0], memf(bus_addr)};
          bus_ack = 1'b1;
          k++;
          fresh = 1;
          if (k == n) after_last = 1;
        end else begin
          waitc--;
          fresh = 0;
        end
      end
      @(negedge clk);
      bus_ack = 1'b0;
    end
    gap++;
    // R3: number of byte cycles
    chk(k == n, "R3 byte count", k, n);
    // R11: done spacing after last ack
    chk(gap == (st ? 1 : 2), "R11 done timing", gap, st ? 1 : 2);
    if (!st) begin
      chk(saw_wb, "R11 writeback seen", 32'(saw_wb), 1);
      expv = lng ? accv : {dval[31:16], accv[15:0]};
      @(negedge clk);
      // R8 R9: loaded register value
      chk(dregs[op[11:9]] == expv, lng ? "R8 long load" : "R9 word load",
          dregs[op[11:9]], expv);
    end
    for (int i = 0; i < 8; i++)
      if (aregs[i] != asave[i]) chk(0, "R9 areg untouched", aregs[i], asave[i]);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin
      dregs[i] = $urandom();
      aregs[i] = $urandom();
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done && !rf_wr_en, "reset state", 32'(busy), 0);

    // R1 R2: decode over random and directed opcodes
    for (int i = 0; i < 300; i++) begin
      logic [15:0] op;
      bit en;
      op = (i % 3 == 0) ? ((16'($urandom()) & 16'h0E07) | 16'h0108 | (16'(i) & 16'h00C0))
                        : 16'($urandom());
      en = (i % 7) != 0;
      opcode = op; cfg_en = en;
      #1;
      chk(match == exp_match(en, op), "R1 match", 32'(match), 32'(exp_match(en, op)));
      chk(rf_dreg_idx == op[11:9] && rf_areg_idx == op[2:0], "R2 indices",
          {26'h0, rf_dreg_idx, rf_areg_idx}, {26'h0, op[11:9], op[2:0]});
      @(negedge clk);
    end
    opcode = 16'h0148; cfg_en = 1'b0; #1;
    chk(match == 1'b0, "R1 disabled", 32'(match), 0);

    // R12: start with no match
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      cfg_en = (i == 1); opcode = (i == 1) ? 16'h0100 : 16'h01C8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 3; c++) begin
        chk(!busy && !bus_req, "R12 no claim", 32'(busy), 0);
        @(negedge clk);
      end
    end
    cfg_en = 1'b1;

    // directed corners: all four modes, zero wait, negative disp, wraparound
    aregs[1] = 32'hFFFF_FFFE;
    dregs[2] = 32'hDEAD_BEEF;
    run_instr(16'h05C9, 16'h0000, 0);   // long store, wrap
    run_instr(16'h0589, 16'h0001, 0);   // word store
    aregs[3] = 32'h0000_1000;
    run_instr(16'h074B, 16'h8000, 0);   // long load, negative disp
    dregs[4] = 32'h1234_5678;
    run_instr(16'h090B, 16'hFFFE, 2);   // word load, keep upper

    for (int i = 0; i < 60; i++) begin
      logic [15:0] op;
      op = 16'h0108 | (16'($urandom_range(7, 0)) << 9) |
           (16'($urandom_range(3, 0)) << 6) | 16'($urandom_range(7, 0));
      run_instr(op, 16'($urandom()), int'($urandom_range(3, 0)));
    end

    finished = 1;
    report();
    $finish;
  end
endmodule